// File: doc/BRIEF.md
# Eight-Operation Arithmetic Logic Unit

This block is a stateless arithmetic logic unit. It takes two operands and a three-bit operation code, and from these it forms one result word and two flags. The eight operations are:

- addition and subtraction;
- four bitwise logic functions;
- a signed less-than compare;
- an unsigned less-than compare.

One adder serves both addition and subtraction. Subtraction adds the inverted second operand with a carry-in of one. Both compares read flags from that same adder while it subtracts. The unsigned compare needs no comparator of its own: its answer is the inverted carry.

The unit has no clock and holds no state. A datapath places it between its operand sources and its write-back stage. The selected result and the flags settle combinationally from the current inputs. The operand width is a parameter, with a default of 32.

Top module: `alu8_core`

## Requirements
- R1: The operation code selects as follows: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 signed less-than, 7 unsigned less-than.
- R2: For add, `result` is (A + B) modulo 2^WIDTH and `carry_out` is the carry out of the top bit.
- R3: For subtract, `result` is (A − B) modulo 2^WIDTH. `carry_out` is 1 exactly when A ≥ B as unsigned numbers.
- R4: `carry_out` is 0 for every operation other than add and subtract.
- R5: `zero` is 1 exactly when the selected result word is all zeros, for every operation.
- R6: AND, OR, XOR and NOR are applied bit by bit; NOR gives the inverse of A OR B in every bit.
- R7: Signed less-than gives 1 when A < B as two's-complement numbers and 0 otherwise. This holds when A − B overflows; for example A = 0x80000000 and B = 0x00000001 gives 1.
- R8: Unsigned less-than gives the inverse of the carry out of the shared adder computing A − B.
- R9: For both compares, result bits WIDTH−1 down to 1 are zero.
- R10: The outputs follow a change of the inputs with no clock edge.
- R11: 0xFFFFFFFF plus 0x00000001 gives result 0, with `zero` at 1 and `carry_out` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected result word |
| zero | output | 1 | Result is all zeros |
| carry_out | output | 1 | Adder carry for add and subtract, 0 for all other operations |

## Verification
Two flags can be raised by the same input pattern: `zero` and `carry_out` are both set when an add wraps to zero, or when a subtract has equal operands. Both cases appear in the exhaustive sweep of a 4-bit instance. They are also driven in directed 32-bit cases at the all-ones-plus-one boundary. Both flags and the result word are compared in the same sample against arithmetic computed in the bench. The signed compare is checked at the same sign boundaries where the subtractor overflows.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOR  = 3'd5,
    OP_SLT  = 3'd6,
    OP_SLTU = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int FULL_W = WIDTH + 1;

  logic [WIDTH-1:0]  b_eff;
  logic [FULL_W-1:0] full;

  // Subtraction adds the inverted operand with a carry-in of one
  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
  assign sum   = full[WIDTH-1:0];
  assign cout  = full[WIDTH];
  // Signed overflow: both adder inputs share a sign that the sum does not
  assign ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] nor_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
    assign xor_o[i] = a[i] ^ b[i];
    assign nor_o[i] = ~(a[i] | b[i]);
  end
endmodule

// File: rtl/alu8_compare.sv
module alu8_compare #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] diff,
  input  logic             cout,
  input  logic             ovf,
  output logic [WIDTH-1:0] slt_o,
  output logic [WIDTH-1:0] sltu_o
);
  localparam int PAD_W = WIDTH - 1;

  logic lt_signed;
  logic lt_unsigned;

  // Sign of the difference, corrected when the subtraction overflowed
  assign lt_signed   = diff[WIDTH-1] ^ ovf;
  // No carry out of A - B means a borrow: A is below B
  assign lt_unsigned = ~cout;
  assign slt_o       = {{PAD_W{1'b0}}, lt_signed};
  assign sltu_o      = {{PAD_W{1'b0}}, lt_unsigned};
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out
);
  import alu8_pkg::*;

  alu_op_e          op;
  logic             do_sub;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] and_w, or_w, xor_w, nor_w;
  logic [WIDTH-1:0] slt_w, sltu_w;

  assign op = alu_op_e'(op_sel);
  // Every operation except add drives the adder as a subtractor
  assign do_sub = (op != OP_ADD);

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(do_sub),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b),
    .and_o(and_w), .or_o(or_w), .xor_o(xor_w), .nor_o(nor_w)
  );

  alu8_compare #(.WIDTH(WIDTH)) u_cmp (
    .diff(add_sum), .cout(add_cout), .ovf(add_ovf),
    .slt_o(slt_w), .sltu_o(sltu_w)
  );

  always_comb begin
    case (op)
      OP_ADD:  result = add_sum;
      OP_SUB:  result = add_sum;
      OP_AND:  result = and_w;
      OP_OR:   result = or_w;
      OP_XOR:  result = xor_w;
      OP_NOR:  result = nor_w;
      OP_SLT:  result = slt_w;
      OP_SLTU: result = sltu_w;
      default: result = '0;
    endcase
  end

  assign carry_out = ((op == OP_ADD) || (op == OP_SUB)) ? add_cout : 1'b0;
  assign zero      = (result == '0);
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             carry_out,
  input logic             add_cout
);
  always_comb begin
    // R2
    if (op_sel == 3'd0)
      add_sum_chk: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
        else $error("add sum/carry mismatch");
    // R4
    if (op_sel > 3'd1)
      carry_gate_chk: assert (carry_out == 1'b0) else $error("carry not gated");
    // R5
    zero_flag_chk: assert (zero == (result == '0)) else $error("zero flag wrong");
    // R9
    if (op_sel >= 3'd6)
      cmp_upper_chk: assert ((result >> 1) == '0) else $error("compare upper bits set");
    // R8
    if (op_sel == 3'd7)
      sltu_carry_chk: assert (result[0] == ~add_cout) else $error("unsigned compare not from carry");
  end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .result(result), .zero(zero), .carry_out(carry_out), .add_cout(add_cout)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W_BIG   = 32;
  localparam int W_SMALL = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0]        op_b, op_s;
  logic [W_BIG-1:0]  a_b, b_b, r_b;
  logic [W_SMALL-1:0] a_s, b_s, r_s;
  logic z_b, c_b, z_s, c_s;

  alu8_core #(.WIDTH(W_BIG)) u_dut (
    .op_sel(op_b), .opnd_a(a_b), .opnd_b(b_b),
    .result(r_b), .zero(z_b), .carry_out(c_b)
  );

  alu8_core #(.WIDTH(W_SMALL)) u_small (
    .op_sel(op_s), .opnd_a(a_s), .opnd_b(b_s),
    .result(r_s), .zero(z_s), .carry_out(c_s)
  );

  // Reference: returns {carry, zero, result} computed arithmetically at width w
  function automatic logic [33:0] ref_model(input int op, input logic [31:0] a,
                                            input logic [31:0] b, input int w);
    logic [32:0] mask, s, res;
    logic cy, sa, sb, lt_s;
    mask = (33'd1 << w) - 33'd1;
    cy = 1'b0;
    sa = a[w-1];
    sb = b[w-1];
    lt_s = (sa != sb) ? sa : (a < b);
    case (op)
      0: begin s = {1'b0, a} + {1'b0, b}; res = s & mask; cy = s[w]; end
      1: begin res = ({1'b0, a} - {1'b0, b}) & mask; cy = (a >= b); end
      2: res = {1'b0, a & b};
      3: res = {1'b0, a | b};
      4: res = {1'b0, a ^ b};
      5: res = {1'b0, ~(a | b)} & mask;
      6: res = {32'd0, lt_s};
      default: res = {32'd0, (a < b)};
    endcase
    return {cy, (res == 33'd0), res[31:0]};
  endfunction

  function automatic string res_tag(input int op);
    case (op)
      0: return "R1/R2";
      1: return "R1/R3";
      2, 3, 4, 5: return "R1/R6";
      6: return "R7/R9";
      default: return "R8/R9";
    endcase
  endfunction

  task automatic judge(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] res, input logic zf, input logic cf,
                       input int w, input string note);
    logic [33:0] e;
    e = ref_model(op, a, b, w);
    checks++;
    if (res !== e[31:0] || zf !== e[32] || cf !== e[33]) begin
      errors++;
      if (res !== e[31:0])
        $display("FAIL %s %s op=%0d a=%h b=%h result actual=%h expected=%h",
                 res_tag(op), note, op, a, b, res, e[31:0]);
      if (zf !== e[32])
        $display("FAIL R5 %s op=%0d a=%h b=%h zero actual=%b expected=%b",
                 note, op, a, b, zf, e[32]);
      if (cf !== e[33])
        $display("FAIL %s %s op=%0d a=%h b=%h carry actual=%b expected=%b",
                 (op < 2) ? "R2/R3" : "R4", note, op, a, b, cf, e[33]);
    end
  endtask

  task automatic big(input int op, input logic [31:0] a, input logic [31:0] b, input string note);
    @(posedge clk);
    op_b = op[2:0]; a_b = a; b_b = b;
    @(negedge clk);
    judge(op, a, b, r_b, z_b, c_b, W_BIG, note);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op_b = 3'd0; a_b = '0; b_b = '0;
    op_s = 3'd0; a_s = '0; b_s = '0;
    @(negedge clk);
    // R5: all-zero inputs give result 0 with zero set
    judge(0, 32'd0, 32'd0, r_b, z_b, c_b, W_BIG, "idle inputs");

    // Exhaustive sweep of the 4-bit instance: R1..R9, including coincident zero+carry
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          op_s = op[2:0]; a_s = a[3:0]; b_s = b[3:0];
          @(negedge clk);
          judge(op, {28'd0, a_s}, {28'd0, b_s}, {28'd0, r_s}, z_s, c_s, W_SMALL, "sweep4");
        end

    // R11: all-ones plus one wraps with zero and carry together
    big(0, 32'hFFFF_FFFF, 32'h0000_0001, "R11 wrap");
    big(1, 32'h1234_5678, 32'h1234_5678, "R3 equal sub");
    big(1, 32'h0000_0000, 32'h0000_0001, "R3 borrow");
    // R7: signed compare where the subtractor overflows
    big(6, 32'h8000_0000, 32'h0000_0001, "R7 overflow min");
    big(6, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R7 overflow max");
    big(6, 32'hFFFF_FFFF, 32'h0000_0000, "R7 neg vs zero");
    big(6, 32'h0000_0005, 32'h0000_0005, "R7 equal");
    // R8: unsigned view of the same patterns
    big(7, 32'h8000_0000, 32'h0000_0001, "R8 high vs low");
    big(7, 32'h0000_0001, 32'hFFFF_FFFF, "R8 low vs high");
    big(5, 32'h0F0F_0000, 32'h00F0_F0F0, "R6 nor");
    big(5, 32'h0000_0000, 32'h0000_0000, "R6 nor all ones");
    big(4, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R6 xor zero");
    big(2, 32'hFFFF_0000, 32'h00FF_FF00, "R6 and");
    big(3, 32'hA5A5_0000, 32'h0000_5A5A, "R6 or");
    big(0, 32'h8000_0000, 32'h8000_0000, "R2 carry to zero");
    for (int k = 0; k < 32; k++) begin
      big(k % 8, 32'h9E37_79B9 * (k + 1), 32'h7F4A_7C15 ^ (k * 32'h0101_0101), "mix");
    end

    // R10: inputs changed between edges, outputs sampled without an edge
    @(negedge clk);
    op_b = 3'd1; a_b = 32'd10; b_b = 32'd3;
    #1;
    judge(1, 32'd10, 32'd3, r_b, z_b, c_b, W_BIG, "R10 no edge");
    op_b = 3'd7; a_b = 32'd2; b_b = 32'd9;
    #1;
    judge(7, 32'd2, 32'd9, r_b, z_b, c_b, W_BIG, "R10 no edge");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule